// File: doc/BRIEF.md
# Decimal Field Length Sequencer

This block steps through the operand fields of a byte-serial decimal add or subtract unit. A start pulse loads a one-byte length count and the starting address of the B field. After that, each B-field storage strobe moves the working count and the working address down by one, from the low-order end toward the high-order end. The block reports the cycle in which the last byte of the field is handled.

If the arithmetic unit finds that the result must be recomplemented, it raises a recomplement request once the first pass has ended. The block then restores the B-field start address from its recall register and switches to a second counter. That counter was loaded with the same length at start. It counts down again, this time on recomplement strobes. In both passes the first strobe does not decrement. A field with length code L therefore takes L+2 strobes.

A 16-bit status word pairs the recall length (high byte) with a saved condition byte (low byte). The condition byte is written on a program-level-change strobe and is presented on a restore strobe.

Five named states make up the controller:

| State | Meaning |
|---|---|
| ST_IDLE | After reset; nothing has started |
| ST_MAIN | First pass, counting on B strobes |
| ST_MAIN_END | First pass finished |
| ST_RCMP | Recomplement pass, counting on recomplement strobes |
| ST_RCMP_END | Recomplement pass finished |

The transitions between them are:

| Transition | Condition |
|---|---|
| any state → ST_MAIN | on `start` |
| ST_MAIN → ST_MAIN_END | on the final B strobe |
| ST_MAIN_END → ST_RCMP | on an accepted `recomp_req` |
| ST_RCMP → ST_RCMP_END | on the final recomplement strobe |

Top module: `dec_len_seq`

## Requirements
- R1: A `start` pulse loads `len_in` into both the working count and the recall count, and loads `baddr_in` into both the working address and the address recall register. After the edge, `count` = `len_in`, `cur_addr` = `baddr_in`, and `pass_done` and `in_rcmp` are 0.
- R2: The first counting strobe of each pass (`bcyc` in the main pass, `rcyc` in the recomplement pass) changes neither `count` nor `cur_addr`.
- R3: Every later counting strobe that arrives while `count` is nonzero lowers `count` by one and lowers `cur_addr` by one, modulo 2^AW.
- R4: `field_done` is 1 combinationally in the cycle of a non-first counting strobe that arrives while `count` is 0. From the next cycle on, `pass_done` is 1, so a length code L takes L+2 strobes.
- R5: While a pass is finished (`pass_done`=1), and also in the idle state after reset, `bcyc` and `rcyc` have no effect on `count`, `cur_addr` or `pass_done`.
- R6: A `recomp_req` is accepted only when the main pass has finished (`pass_done`=1, `in_rcmp`=0). At any other time it is ignored and leaves `in_rcmp` and `cur_addr` unchanged.
- R7: When a recomplement request is accepted, after the edge `in_rcmp` = 1, `pass_done` = 0, `cur_addr` = the start address loaded by `start`, and `count` shows the recall count, which equals the loaded length.
- R8: During the main pass, `rcyc` is ignored. During the recomplement pass, `bcyc` is ignored, and `rcyc` counts under the same first-strobe and done rules as R2 to R4.
- R9: `start` takes priority in every state, including a cycle that also carries a strobe or a recomplement request. In that cycle `field_done` is 0.
- R10: `lvl_save` loads `cond_in` into the low byte of `psr_out`. The high byte of `psr_out` is the recall count. `cond_out` equals the saved byte while `lvl_restore` is 1 and is 0 otherwise. A save in the same cycle as a restore returns the older byte.
- R11: After reset the block is in ST_IDLE with `count`, `cur_addr`, `psr_out`, `pass_done`, `in_rcmp` and `field_done` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new instruction |
| len_in | input | LW | Field length code |
| baddr_in | input | AW | B-field start address (low-order end) |
| bcyc | input | 1 | B-field storage cycle strobe |
| rcyc | input | 1 | Recomplement cycle strobe |
| recomp_req | input | 1 | Request a recomplement pass |
| lvl_save | input | 1 | Program-level change: save the condition byte |
| lvl_restore | input | 1 | Present the saved condition byte |
| cond_in | input | LW | Condition byte to save |
| count | output | LW | Active counter (working count, or recall count during recomplement) |
| cur_addr | output | AW | Current B-field address |
| field_done | output | 1 | Last byte of the field in this cycle |
| pass_done | output | 1 | Current pass finished |
| in_rcmp | output | 1 | Recomplement pass selected |
| psr_out | output | 2*LW | Recall count and saved condition byte |
| cond_out | output | LW | Restored condition byte |

## Verification
The hardest case to reach is the recomplement replay. To get there the first pass must run to completion, and then strobes of the wrong kind and early requests must be shown to leave the state alone. The directed sequence drives a full first pass with interleaved `rcyc` strobes and a premature `recomp_req`, and then a complete recomplement pass. After that it sends a second request in ST_RCMP_END, starts a new instruction over a live strobe, and runs a pass whose address wraps past zero. Long random stretches follow, with sparse starts and frequent requests, so that every state meets every input pattern.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAIN,
        ST_MAIN_END,
        ST_RCMP,
        ST_RCMP_END
    } seq_state_t;

endpackage

// File: rtl/dls_lencnt.sv
// Down counter with a skip on the first strobe after loading or arming.
module dls_lencnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         arm,
    input  logic         strobe,
    output logic [W-1:0] cnt,
    output logic         last,
    output logic         step
);

    logic first_q;

    always_comb begin
        last = strobe && !first_q && (cnt == '0);
        step = strobe && !first_q && (cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            first_q <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            first_q <= 1'b1;
        end else begin
            if (arm) begin
                first_q <= 1'b1;
            end else if (strobe) begin
                first_q <= 1'b0;
            end
            if (step) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dls_addr.sv
// Working B-field address with its recall copy.
module dls_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          restore,
    input  logic          dec,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] recall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            recall_q <= '0;
        end else if (load) begin
            cur_addr <= load_val;
            recall_q <= load_val;
        end else if (restore) begin
            cur_addr <= recall_q;
        end else if (dec) begin
            cur_addr <= cur_addr - 1'b1;
        end
    end

endmodule

// File: rtl/dls_status.sv
// Status word: recall length in the high byte, saved condition in the low byte.
module dls_status #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           save,
    input  logic [W-1:0]   cond_in,
    input  logic           restore,
    input  logic [W-1:0]   rlen,
    output logic [2*W-1:0] psr_out,
    output logic [W-1:0]   cond_out
);

    logic [W-1:0] cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (save) begin
            cond_q <= cond_in;
        end
    end

    always_comb begin
        psr_out  = {rlen, cond_q};
        cond_out = restore ? cond_q : '0;
    end

endmodule

// File: rtl/dls_fsm.sv
// Pass controller for the main and recomplement passes.
module dls_fsm
    import dls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic recomp_req,
    input  logic bcyc,
    input  logic rcyc,
    input  logic main_last,
    input  logic rcmp_last,
    output logic main_stb,
    output logic rcmp_stb,
    output logic recomp_acc,
    output logic field_done,
    output logic pass_done,
    output logic in_rcmp
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_MAIN;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_MAIN:     if (main_last) state_d = ST_MAIN_END;
                ST_MAIN_END: if (recomp_req) state_d = ST_RCMP;
                ST_RCMP:     if (rcmp_last) state_d = ST_RCMP_END;
                ST_RCMP_END: state_d = ST_RCMP_END;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        main_stb   = 1'b0;
        rcmp_stb   = 1'b0;
        recomp_acc = 1'b0;
        pass_done  = 1'b0;
        in_rcmp    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MAIN: main_stb = bcyc && !start;
            ST_MAIN_END: begin
                pass_done  = 1'b1;
                recomp_acc = recomp_req && !start;
            end
            ST_RCMP: begin
                in_rcmp  = 1'b1;
                rcmp_stb = rcyc && !start;
            end
            ST_RCMP_END: begin
                in_rcmp   = 1'b1;
                pass_done = 1'b1;
            end
            default: ;
        endcase
        field_done = (main_stb && main_last) || (rcmp_stb && rcmp_last);
    end

endmodule

// File: rtl/dec_len_seq.sv
module dec_len_seq #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LW-1:0]   len_in,
    input  logic [AW-1:0]   baddr_in,
    input  logic            bcyc,
    input  logic            rcyc,
    input  logic            recomp_req,
    input  logic            lvl_save,
    input  logic            lvl_restore,
    input  logic [LW-1:0]   cond_in,
    output logic [LW-1:0]   count,
    output logic [AW-1:0]   cur_addr,
    output logic            field_done,
    output logic            pass_done,
    output logic            in_rcmp,
    output logic [2*LW-1:0] psr_out,
    output logic [LW-1:0]   cond_out
);

    logic          main_stb, rcmp_stb, recomp_acc;
    logic          main_last, rcmp_last, main_step, rcmp_step;
    logic [LW-1:0] main_cnt, rcmp_cnt;

    dls_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .recomp_req (recomp_req),
        .bcyc       (bcyc),
        .rcyc       (rcyc),
        .main_last  (main_last),
        .rcmp_last  (rcmp_last),
        .main_stb   (main_stb),
        .rcmp_stb   (rcmp_stb),
        .recomp_acc (recomp_acc),
        .field_done (field_done),
        .pass_done  (pass_done),
        .in_rcmp    (in_rcmp)
    );

    dls_lencnt #(.W(LW)) u_main_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (len_in),
        .arm      (1'b0),
        .strobe   (main_stb),
        .cnt      (main_cnt),
        .last     (main_last),
        .step     (main_step)
    );

    dls_lencnt #(.W(LW)) u_rcmp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (len_in),
        .arm      (recomp_acc),
        .strobe   (rcmp_stb),
        .cnt      (rcmp_cnt),
        .last     (rcmp_last),
        .step     (rcmp_step)
    );

    dls_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (baddr_in),
        .restore  (recomp_acc),
        .dec      (main_step || rcmp_step),
        .cur_addr (cur_addr)
    );

    dls_status #(.W(LW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .save     (lvl_save),
        .cond_in  (cond_in),
        .restore  (lvl_restore),
        .rlen     (rcmp_cnt),
        .psr_out  (psr_out),
        .cond_out (cond_out)
    );

    always_comb begin
        count = in_rcmp ? rcmp_cnt : main_cnt;
    end

endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          recomp_req,
    input logic          lvl_restore,
    input logic [LW-1:0] count,
    input logic [AW-1:0] cur_addr,
    input logic          field_done,
    input logic          pass_done,
    input logic          in_rcmp,
    input logic [LW-1:0] cond_out
);

    // R4
    fd_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> (count == '0));

    // R4
    fd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_done && !start) |=> pass_done);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_done && !start && !(recomp_req && !in_rcmp))
        |=> (pass_done && $stable(cur_addr) && $stable(count)));

    // R3
    count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(recomp_req && pass_done && !in_rcmp)) |=> (count <= $past(count)));

    // R6
    early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recomp_req && !pass_done && !start) |=> (in_rcmp == $past(in_rcmp)));

    // R7
    req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recomp_req && pass_done && !in_rcmp && !start) |=> (in_rcmp && !pass_done));

    // R9
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!pass_done && !in_rcmp));

    // R9
    start_no_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !field_done);

    // R10
    cond_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_restore |-> (cond_out == '0));

endmodule

bind dec_len_seq dls_chk #(.AW(AW), .LW(LW)) u_dls_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .recomp_req  (recomp_req),
    .lvl_restore (lvl_restore),
    .count       (count),
    .cur_addr    (cur_addr),
    .field_done  (field_done),
    .pass_done   (pass_done),
    .in_rcmp     (in_rcmp),
    .cond_out    (cond_out)
);

// File: tb/test_dec_len_seq.sv
module test_dec_len_seq;

    localparam int AW = 16;
    localparam int LW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [LW-1:0]   len_in = '0;
    logic [AW-1:0]   baddr_in = '0;
    logic            bcyc = 1'b0;
    logic            rcyc = 1'b0;
    logic            recomp_req = 1'b0;
    logic            lvl_save = 1'b0;
    logic            lvl_restore = 1'b0;
    logic [LW-1:0]   cond_in = '0;
    logic [LW-1:0]   count;
    logic [AW-1:0]   cur_addr;
    logic            field_done;
    logic            pass_done;
    logic            in_rcmp;
    logic [2*LW-1:0] psr_out;
    logic [LW-1:0]   cond_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 main, 2 main end, 3 recomp, 4 recomp end
    int m_st = 0;
    int m_cnt = 0, m_rcnt = 0, m_addr = 0, m_arr = 0, m_crr = 0;
    bit m_first = 0, m_rfirst = 0;

    always #2.5ns clk = ~clk;

    dec_len_seq #(.AW(AW), .LW(LW)) i_dec_len_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in), .baddr_in(baddr_in),
        .bcyc(bcyc), .rcyc(rcyc), .recomp_req(recomp_req), .lvl_save(lvl_save),
        .lvl_restore(lvl_restore), .cond_in(cond_in), .count(count), .cur_addr(cur_addr),
        .field_done(field_done), .pass_done(pass_done), .in_rcmp(in_rcmp),
        .psr_out(psr_out), .cond_out(cond_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit ap, ar;
        int fd;
        ap = (m_st == 1) && bcyc && !start;
        ar = (m_st == 3) && rcyc && !start;
        fd = ((ap && !m_first && m_cnt == 0) || (ar && !m_rfirst && m_rcnt == 0)) ? 1 : 0;
        chk("R3 count", int'(count), (m_st >= 3) ? m_rcnt : m_cnt);
        chk("R3 cur_addr", int'(cur_addr), m_addr);
        chk("R4 field_done", int'(field_done), fd);
        chk("R5 pass_done", int'(pass_done), (m_st == 2 || m_st == 4) ? 1 : 0);
        chk("R7 in_rcmp", int'(in_rcmp), (m_st >= 3) ? 1 : 0);
        chk("R10 psr_out", int'(psr_out), (m_rcnt << LW) | m_crr);
        chk("R10 cond_out", int'(cond_out), lvl_restore ? m_crr : 0);
    endtask

    task automatic model_step();
        bit ap, ar;
        ap = (m_st == 1) && bcyc && !start;
        ar = (m_st == 3) && rcyc && !start;
        if (start) begin
            m_cnt = int'(len_in); m_rcnt = int'(len_in);
            m_first = 1; m_rfirst = 1;
            m_addr = int'(baddr_in); m_arr = int'(baddr_in);
            m_st = 1;
        end else if (ap) begin
            if (m_first) m_first = 0;
            else if (m_cnt == 0) m_st = 2;
            else begin m_cnt--; m_addr = (m_addr - 1) & 16'hFFFF; end
        end else if (ar) begin
            if (m_rfirst) m_rfirst = 0;
            else if (m_rcnt == 0) m_st = 4;
            else begin m_rcnt--; m_addr = (m_addr - 1) & 16'hFFFF; end
        end else if (m_st == 2 && recomp_req) begin
            m_addr = m_arr; m_rfirst = 1; m_st = 3;
        end
        if (lvl_save) m_crr = int'(cond_in);
    endtask

    // one clock: drive at the falling edge, compare, step the model, settle after the rising edge
    task automatic cyc(input bit s, input int len, input int ba, input bit b, input bit r,
                       input bit rq, input bit sv, input bit rs, input int ci);
        @(negedge clk);
        start = s; len_in = LW'(len); baddr_in = AW'(ba); bcyc = b; rcyc = r;
        recomp_req = rq; lvl_save = sv; lvl_restore = rs; cond_in = LW'(ci);
        #1ns;
        compare_model();
        model_step();
        @(posedge clk);
        #1ns;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic bstb(); cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
    task automatic rstb(); cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 count", int'(count), 0);
        chk("R11 cur_addr", int'(cur_addr), 0);
        chk("R11 psr_out", int'(psr_out), 0);
        chk("R11 flags", int'({field_done, pass_done, in_rcmp}), 0);
        rst_n = 1'b1;
        bstb(); rstb();
        chk("R11 strobes idle", int'(count), 0);

        // main pass, length 3
        cyc(1, 3, 'h1000, 0, 0, 0, 0, 0, 0);
        chk("R1 count", int'(count), 3);
        chk("R1 cur_addr", int'(cur_addr), 'h1000);
        bstb();
        chk("R2 first strobe count", int'(count), 3);
        chk("R2 first strobe addr", int'(cur_addr), 'h1000);
        bstb();
        chk("R3 count", int'(count), 2);
        chk("R3 cur_addr", int'(cur_addr), 'h0FFF);
        rstb();
        chk("R8 rcyc in main", int'(count), 2);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R6 early request", int'(in_rcmp), 0);
        bstb(); bstb();
        chk("R3 zero reached", int'(count), 0);
        bstb();
        chk("R4 pass_done", int'(pass_done), 1);
        bstb(); rstb();
        chk("R5 addr held", int'(cur_addr), 'h0FFD);

        // recomplement pass
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R7 in_rcmp", int'(in_rcmp), 1);
        chk("R7 addr restored", int'(cur_addr), 'h1000);
        chk("R7 count recalled", int'(count), 3);
        rstb();
        chk("R8 first rcyc", int'(count), 3);
        bstb();
        chk("R8 bcyc in recomp", int'(count), 3);
        rstb(); rstb(); rstb();
        chk("R8 recomp counted", int'(cur_addr), 'h0FFD);
        rstb();
        chk("R8 recomp done", int'(pass_done), 1);
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
        chk("R6 request after recomp", int'(cur_addr), 'h0FFD);

        // zero length with wrap, then start over a live strobe
        cyc(1, 0, 'h0000, 0, 0, 0, 0, 0, 0);
        bstb(); bstb();
        chk("R4 zero length", int'(pass_done), 1);
        cyc(1, 4, 'h0001, 0, 0, 0, 0, 0, 0);
        repeat (4) bstb();
        chk("R3 wrap", int'(cur_addr), 'hFFFE);
        cyc(1, 7, 'h2345, 1, 1, 1, 0, 0, 0);
        chk("R9 start wins", int'(count), 7);
        chk("R9 start addr", int'(cur_addr), 'h2345);

        // status byte
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 'hA5);
        chk("R10 saved", int'(psr_out[LW-1:0]), 'hA5);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 'h3C);
        chk("R10 resaved", int'(psr_out), (7 << LW) | 'h3C);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);

        // random stretch
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 40) == 0, $urandom % 8, $urandom, $urandom % 2, $urandom % 2,
                ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0, $urandom);
        end
        idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule